// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects up to 32 interrupt sources for a processor core, holds each request in a sticky pending bit, and offers the core one request at a time: the pending, enabled slot that ranks highest in a fixed priority order. Alongside the request it gives the slot number and an absolute vector address. The address is formed from one of two programmable 16-bit base pointers. Slots 16 to 23 use the upper-page pointer and every other slot uses the lower-page pointer.

Hardware sources arrive as active-low asynchronous lines. They are brought into the clock domain by a two-flop synchronizer and recognised on their falling edge. Some slots are fed by two sources. Slots 7, 11 and 13 merge two independent edges. The watchdog source can instead be steered to the nonmaskable slot. Slot 19 merges an external pin with a clock event as a wired level, so a pin held low hides the clock event. A software trap port can raise any slot by number, and it is the only way to raise slots 27 to 31.

The core services a request by pulsing an acknowledge. That pulse clears the granted slot's pending bit and drops the request. A new winner is chosen on the next cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `irq_o` is high, `vec_addr_o` equals (base << 8) | (slot × 8), where slot is `irq_num_o`. The base is the upper-page pointer (`reg_sel_i`=1) for slots 16–23 and the lower-page pointer (`reg_sel_i`=0) for all other slots.
- R2: Among eligible pending slots, the winner follows this rank order, highest first: 0, 1, 24, 2, 16, 3, 4, 5, 17, 6, 7, 8, 18, 9, 10, 11, 19, 12, 13, 20, 21, 14, 15, 22, 23, 25, 26, 27, 28, 29, 30, 31.
- R3: A slot from 2 to 31 is eligible only when `gie_i` is 1 and bit slot of `ie_mask_i` is 1. Slots 0 and 1 ignore both. A masked request stays pending and is granted once it is enabled.
- R4: Once `irq_o` rises, `irq_o`, `irq_num_o` and `vec_addr_o` hold their values until a cycle with `ack_i`=1, even if a higher-ranked request arrives.
- R5: `ack_i` while `irq_o` is high clears that slot's pending bit, and `irq_o` is low in the following cycle. A new set of the same slot in the acknowledge cycle wins over the clear.
- R6: A falling edge on `req_n_i[s]` (slots 0, 2–26) sets pending bit s. A line held low does not set it again. `req_n_i[1]` and `req_n_i[31:27]` have no effect.
- R7: Slot 19 is raised by a falling edge of the AND of `req_n_i[19]` and `alt_n_i[3]`. A clock-event edge on `alt_n_i[3]` while `req_n_i[19]` is low raises nothing.
- R8: A falling edge of `alt_n_i[0]` raises slot 7 and a falling edge of `alt_n_i[2]` raises slot 13. A falling edge of `alt_n_i[1]` raises slot 1 when `wdog_nmi_i` is 1, and slot 11 otherwise.
- R9: `trap_vld_i`=1 sets the pending bit of slot `trap_num_i`, for any slot 0–31.
- R10: After reset, `irq_o`=0, `irq_num_o`=0 and `vec_addr_o`=0, with no request pending and both pointers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 32 | Active-low hardware request line per slot |
| alt_n_i | input | 4 | Active-low second sources: [0] slot 7, [1] watchdog, [2] slot 13, [3] clock event on slot 19 |
| wdog_nmi_i | input | 1 | Steers the watchdog source to slot 1 (1) or slot 11 (0) |
| trap_vld_i | input | 1 | Software trap strobe |
| trap_num_i | input | 5 | Slot raised by the trap |
| ie_mask_i | input | 32 | Per-slot enable mask |
| gie_i | input | 1 | Global enable for maskable slots |
| reg_we_i | input | 1 | Base pointer write strobe |
| reg_sel_i | input | 1 | Pointer select: 0 lower page, 1 upper page |
| reg_wdata_i | input | 16 | Pointer write data |
| ack_i | input | 1 | Acknowledge of the current grant |
| irq_o | output | 1 | Interrupt request to the core |
| irq_num_o | output | 5 | Granted slot number |
| vec_addr_o | output | 24 | Absolute vector address of the granted slot |

## Verification
A lost or stuck pending bit shows at the ports in one of two ways. A slot may fail to be granted after it is enabled or after the grant above it is acknowledged. Or the same slot may come back one cycle after its acknowledge. A wrong rank or base choice shows as a wrong `irq_num_o` or `vec_addr_o` on the first grant cycle. A broken edge detector or synchronizer shows three cycles after a pin change: either no grant, or a repeated grant while the line stays low. The slot 19 merge is checked by showing that a clock event hidden under a low pin never reaches the port.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NSLOT  = 32;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int NALT   = 4;

    // slots fed by a second source
    localparam int SLOT_NMI   = 1;
    localparam int SLOT_CARD1 = 7;
    localparam int SLOT_WDOG  = 11;
    localparam int SLOT_CARD2 = 13;
    localparam int SLOT_MERGE = 19;

    // slots without a hardware line
    localparam int SLOT_SW_FIRST = 27;

    // upper-page slot window
    localparam int HI_FIRST = 16;
    localparam int HI_LAST  = 23;

    // fixed arbitration order: rank -> slot
    function automatic logic [SLOT_W-1:0] rank_slot(input int rank);
        case (rank)
            0:  return 5'd0;   1:  return 5'd1;   2:  return 5'd24;  3:  return 5'd2;
            4:  return 5'd16;  5:  return 5'd3;   6:  return 5'd4;   7:  return 5'd5;
            8:  return 5'd17;  9:  return 5'd6;   10: return 5'd7;   11: return 5'd8;
            12: return 5'd18;  13: return 5'd9;   14: return 5'd10;  15: return 5'd11;
            16: return 5'd19;  17: return 5'd12;  18: return 5'd13;  19: return 5'd20;
            20: return 5'd21;  21: return 5'd14;  22: return 5'd15;  23: return 5'd22;
            24: return 5'd23;  default: return SLOT_W'(rank + 0);
        endcase
    endfunction

endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
    parameter int WIDTH = 36,
    parameter int STAGES_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= {WIDTH{STAGES_RST[0]}};
            st_q.s2 <= {WIDTH{STAGES_RST[0]}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

    // R6: second stage only copies what the first stage held a cycle earlier
    a_r6_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_o == $past(st_q.s1));

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  elig_i,
    output logic              vld_o,
    output logic [SLOT_W-1:0] slot_o
);
    always_comb begin
        vld_o  = 1'b0;
        slot_o = '0;
        for (int rank = NSLOT - 1; rank >= 0; rank--) begin
            if (elig_i[rank_slot(rank)]) begin
                vld_o  = 1'b1;
                slot_o = rank_slot(rank);
            end
        end
    end

    // R2: a winner is always one of the eligible slots
    a_r2_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> elig_i[slot_o]);

    // R2: top-ranked slot 0 always wins when eligible
    a_r2_slot0_first: assert property (@(posedge clk) disable iff (!rst_n)
        elig_i[0] |-> (vld_o && slot_o == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int PAGE_SH = 8,
    parameter int ENTRY_SH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       req_n_i,
    input  logic [3:0]        alt_n_i,
    input  logic              wdog_nmi_i,
    input  logic              trap_vld_i,
    input  logic [4:0]        trap_num_i,
    input  logic [31:0]       ie_mask_i,
    input  logic              gie_i,
    input  logic              reg_we_i,
    input  logic              reg_sel_i,
    input  logic [15:0]       reg_wdata_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [4:0]        irq_num_o,
    output logic [23:0]       vec_addr_o
);
    localparam int ADDR_W = BASE_W + PAGE_SH;
    localparam int NLINE  = NSLOT + NALT;
    localparam int NEDGE  = 3;   // alt sources with their own edge detector

    typedef struct packed {
        logic [NSLOT-1:0]  pend;
        logic [NSLOT-1:0]  prev_lvl;
        logic [NEDGE-1:0]  prev_alt;
        logic              irq;
        logic [SLOT_W-1:0] num;
        logic [ADDR_W-1:0] vec;
        logic [BASE_W-1:0] base_lo;
        logic [BASE_W-1:0] base_hi;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [NLINE-1:0]  sync_l;
    logic [NSLOT-1:0]  lvl;
    logic [NSLOT-1:0]  hw_set;
    logic [NSLOT-1:0]  elig;
    logic              win_vld;
    logic [SLOT_W-1:0] win_slot;
    logic              unused_pins;

    irqv_sync #(.WIDTH(NLINE), .STAGES_RST(1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({alt_n_i, req_n_i}),
        .sync_o  (sync_l)
    );

    // per-slot recognised level, with lines that have no hardware source held idle
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            if (s == SLOT_NMI || s >= SLOT_SW_FIRST) lvl[s] = 1'b1;
            else                                     lvl[s] = sync_l[s];
        end
        lvl[SLOT_MERGE] = sync_l[SLOT_MERGE] & sync_l[NSLOT + 3];
    end

    assign unused_pins = &{sync_l[SLOT_NMI], sync_l[NSLOT-1:SLOT_SW_FIRST]};

    always_comb begin
        logic [NEDGE-1:0] alt_fall;
        alt_fall = st_q.prev_alt & ~sync_l[NSLOT +: NEDGE];
        hw_set   = st_q.prev_lvl & ~lvl;
        hw_set[SLOT_CARD1] = hw_set[SLOT_CARD1] | alt_fall[0];
        hw_set[SLOT_CARD2] = hw_set[SLOT_CARD2] | alt_fall[2];
        if (wdog_nmi_i) hw_set[SLOT_NMI]  = hw_set[SLOT_NMI]  | alt_fall[1];
        else            hw_set[SLOT_WDOG] = hw_set[SLOT_WDOG] | alt_fall[1];
    end

    assign elig = st_q.pend & ((ie_mask_i & {NSLOT{gie_i}}) | NSLOT'(3));

    irqv_arbiter i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig_i (elig),
        .vld_o  (win_vld),
        .slot_o (win_slot)
    );

    always_comb begin
        logic [NSLOT-1:0]  clr;
        logic [NSLOT-1:0]  trap_set;
        logic [BASE_W-1:0] base;
        st_d          = st_q;
        st_d.prev_lvl = lvl;
        st_d.prev_alt = sync_l[NSLOT +: NEDGE];

        clr      = (st_q.irq && ack_i) ? (NSLOT'(1) << st_q.num) : '0;
        trap_set = trap_vld_i ? (NSLOT'(1) << trap_num_i) : '0;
        st_d.pend = (st_q.pend & ~clr) | hw_set | trap_set;

        base = (win_slot >= SLOT_W'(HI_FIRST) && win_slot <= SLOT_W'(HI_LAST))
             ? st_q.base_hi : st_q.base_lo;

        if (st_q.irq) begin
            if (ack_i) st_d.irq = 1'b0;
        end else if (win_vld) begin
            st_d.irq = 1'b1;
            st_d.num = win_slot;
            st_d.vec = {base, {PAGE_SH{1'b0}}}
                     | (ADDR_W'(win_slot) << ENTRY_SH);
        end

        if (reg_we_i) begin
            if (reg_sel_i) st_d.base_hi = reg_wdata_i;
            else           st_d.base_lo = reg_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.prev_lvl <= '1;
            st_q.prev_alt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.irq;
    assign irq_num_o  = st_q.num;
    assign vec_addr_o = st_q.vec;

    // R4: grant held until acknowledged
    a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(irq_num_o) && $stable(vec_addr_o)));

    // R5: acknowledge drops the request in the next cycle
    a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    // R1: vector offset encodes the granted slot
    a_r1_vec_offset: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_addr_o[PAGE_SH-1:0] == (8'(irq_num_o) << ENTRY_SH)));

    // R3: a new grant of a maskable slot was enabled when it was chosen
    a_r3_enabled_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ((irq_num_o < SLOT_W'(2)) ||
                          ($past(gie_i) && ((($past(ie_mask_i) >> irq_num_o) & 32'd1) != 32'd0))));

    // R6: a recognised edge needs the slot idle high the cycle before
    a_r6_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prev_lvl[3] && !lvl[3]) |=> !(st_q.prev_lvl[3] && !lvl[3]));

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_n = '1;
    logic [3:0]  alt_n = '1;
    logic        wdog_nmi = 1'b0;
    logic        trap_vld = 1'b0;
    logic [4:0]  trap_num = '0;
    logic [31:0] mask = '0;
    logic        gie = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] wdata = '0;
    logic        ack = 1'b0;
    logic        irq;
    logic [4:0]  num;
    logic [23:0] vec;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    localparam logic [15:0] BASE_LO = 16'h12AB;
    localparam logic [15:0] BASE_HI = 16'h00C3;

    always #10 clk = ~clk;   // 50 MHz

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .alt_n_i(alt_n),
        .wdog_nmi_i(wdog_nmi), .trap_vld_i(trap_vld), .trap_num_i(trap_num),
        .ie_mask_i(mask), .gie_i(gie), .reg_we_i(we), .reg_sel_i(sel),
        .reg_wdata_i(wdata), .ack_i(ack), .irq_o(irq), .irq_num_o(num),
        .vec_addr_o(vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_vec(input int slot);
        logic [15:0] b;
        b = (slot >= 16 && slot <= 23) ? BASE_HI : BASE_LO;
        return {b, 8'h00} | 24'(slot * 8);
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trap(input int slot);
        @(negedge clk);
        trap_vld = 1'b1;
        trap_num = 5'(slot);
        @(negedge clk);
        trap_vld = 1'b0;
    endtask

    task automatic wr_base(input logic s, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic ack_one;
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic drain;
        mask = '1; gie = 1'b1;
        repeat (80) begin
            @(negedge clk);
            ack = irq;
        end
        ack = 1'b0;
    endtask

    // {mask, trap A, trap B, expect grant, expected slot}
    localparam int NROW = 10;
    localparam logic [47:0] TBL [NROW] = '{
        {32'hFFFF_FFFF, 5'd5,  5'd24, 1'b1, 5'd24},
        {32'hFFFF_FFFF, 5'd16, 5'd2,  1'b1, 5'd2 },
        {32'hFFFF_FFFF, 5'd25, 5'd23, 1'b1, 5'd23},
        {32'hFFFF_FFFF, 5'd17, 5'd6,  1'b1, 5'd17},
        {32'hFFFD_FFFF, 5'd17, 5'd6,  1'b1, 5'd6 },
        {32'h0000_0000, 5'd0,  5'd1,  1'b1, 5'd0 },
        {32'h0000_0000, 5'd30, 5'd1,  1'b1, 5'd1 },
        {32'h0000_0000, 5'd31, 5'd31, 1'b0, 5'd0 },
        {32'hFFFF_FFFF, 5'd19, 5'd12, 1'b1, 5'd19},
        {32'hFFFF_FFFF, 5'd22, 5'd14, 1'b1, 5'd14}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R10: reset state
        chk("R10 irq", 32'(irq), 0);
        chk("R10 num", 32'(num), 0);
        chk("R10 vec", 32'(vec), 0);
        rst_n = 1'b1;
        cycles(4);
        chk("R10 no pending after reset", 32'(irq), 0);

        wr_base(1'b0, BASE_LO);
        wr_base(1'b1, BASE_HI);

        // table walk: R1, R2, R3, R9
        for (int i = 0; i < NROW; i++) begin
            gie = 1'b0; mask = '0;
            trap(int'(TBL[i][15:11]));
            trap(int'(TBL[i][10:6]));
            mask = TBL[i][47:16];
            gie  = 1'b1;
            cycles(3);
            chk($sformatf("R2 row%0d irq", i), 32'(irq), 32'(TBL[i][5]));
            if (TBL[i][5]) begin
                chk($sformatf("R2 row%0d slot", i), 32'(num), 32'(TBL[i][4:0]));
                chk($sformatf("R1 row%0d vec", i), 32'(vec), 32'(exp_vec(int'(TBL[i][4:0]))));
            end
            drain();
        end

        // R3: global disable holds slot 9, slot 1 passes
        gie = 1'b0; mask = '1;
        trap(9); trap(1);
        cycles(3);
        chk("R3 nmi through gie=0", 32'(num), 1);
        ack_one();
        cycles(3);
        chk("R3 masked stays quiet", 32'(irq), 0);
        gie = 1'b1;
        cycles(3);
        chk("R3 retained request granted", 32'(num), 9);
        drain();

        // R4: hold while higher slot arrives
        trap(5);
        cycles(2);
        trap(0);
        cycles(3);
        chk("R4 held slot", 32'(num), 5);
        chk("R4 held vec", 32'(vec), 32'(exp_vec(5)));
        ack_one();
        cycles(2);
        chk("R4 next grant after ack", 32'(num), 0);
        drain();

        // R5: set in the acknowledge cycle is kept
        trap(5);
        cycles(2);
        @(negedge clk);
        ack = 1'b1; trap_vld = 1'b1; trap_num = 5'd5;
        @(negedge clk);
        ack = 1'b0; trap_vld = 1'b0;
        chk("R5 irq low after ack", 32'(irq), 0);
        cycles(2);
        chk("R5 same slot regranted", 32'(irq), 1);
        chk("R5 same slot number", 32'(num), 5);
        drain();

        // R6: pin edge, held level, ignored pins
        @(negedge clk); req_n[3] = 1'b0;
        cycles(6);
        chk("R6 pin edge grant", 32'(num), 3);
        chk("R6 pin edge irq", 32'(irq), 1);
        ack_one();
        cycles(6);
        chk("R6 held low no retrigger", 32'(irq), 0);
        req_n[3] = 1'b1;
        req_n[1] = 1'b0; req_n[28] = 1'b0;
        cycles(6);
        chk("R6 ignored pins", 32'(irq), 0);
        req_n[1] = 1'b1; req_n[28] = 1'b1;
        cycles(4);

        // R7: merged slot 19
        req_n[19] = 1'b0;
        cycles(6);
        chk("R7 pin raises 19", 32'(num), 19);
        ack_one();
        alt_n[3] = 1'b0;
        cycles(6);
        chk("R7 event hidden under low pin", 32'(irq), 0);
        alt_n[3] = 1'b1;
        cycles(3);
        req_n[19] = 1'b1;
        cycles(4);
        alt_n[3] = 1'b0;
        cycles(6);
        chk("R7 event with pin high", 32'(irq), 1);
        chk("R7 event slot", 32'(num), 19);
        ack_one();
        alt_n[3] = 1'b1;
        cycles(4);

        // R8: shared sources
        wdog_nmi = 1'b1; alt_n[1] = 1'b0;
        cycles(6);
        chk("R8 watchdog to slot 1", 32'(num), 1);
        ack_one();
        alt_n[1] = 1'b1; cycles(4);
        wdog_nmi = 1'b0; alt_n[1] = 1'b0;
        cycles(6);
        chk("R8 watchdog to slot 11", 32'(num), 11);
        ack_one();
        alt_n[1] = 1'b1; alt_n[0] = 1'b0;
        cycles(6);
        chk("R8 card source slot 7", 32'(num), 7);
        ack_one();
        alt_n[0] = 1'b1; alt_n[2] = 1'b0;
        cycles(6);
        chk("R8 card source slot 13", 32'(num), 13);
        chk("R1 vec slot 13", 32'(vec), 32'(exp_vec(13)));
        ack_one();
        alt_n[2] = 1'b1;
        cycles(4);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule